// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that lets a bus master read and write a 256-location, byte-addressed configuration space. It samples the bus clock and data lines with the system clock, detects START and STOP conditions, and matches a 7-bit device address. It then runs one of two flows, chosen by the direction bit that follows the address. A write flow takes a word address and then any number of data bytes. A read flow shifts data bytes out, most significant bit first. The data line is open-drain: the block only pulls it low, through an output enable, and reads the wired level back on an input.

A single 8-bit location pointer serves both directions and keeps its value from one transaction to the next. The pointer always ends up one past the last location that was accessed, and it wraps from FFh to 00h. This gives three read styles:

- A bare read continues from where the last access stopped.
- A write that carries only a word address, followed by a repeated START in the read direction, reads from any chosen location.
- Acknowledging each byte streams consecutive locations.

Only two windows, 08h–1Bh and 40h–57h, have storage. A parallel host port gives the rest of the chip direct access to the same storage. If both sides write one location in the same cycle, the bus write wins.

Top module: `i2c_cfg_slave`

## Requirements
- R1: A byte after START whose upper seven bits equal DEV_ADDR (default 69h) is acknowledged: the slave holds the data line low through the ninth clock pulse. The bit 0 of that byte selects the direction: 1 = read, 0 = write.
- R2: A byte whose upper seven bits differ from DEV_ADDR is not acknowledged, and the slave never drives the data line until the next START. Bytes that arrive in the meantime leave the pointer unchanged.
- R3: In a write, the first byte after the address is loaded into the pointer. Each later byte is stored at the pointer, and the pointer then advances by one. Every one of these bytes is acknowledged.
- R4: A write that carries only a word address and is followed by a repeated START in the read direction returns the byte at that word address. That aborted write stores nothing.
- R5: A read that is not preceded by a word address returns the location one past the last location read or written.
- R6: During a read, a master acknowledge after a data byte makes the slave send the next location. The pointer advances once for every byte sent.
- R7: Advancing the pointer from FFh gives 00h, for both reads and writes.
- R8: Locations outside 08h–1Bh and 40h–57h read as 00h. Writes to them are acknowledged and discarded, and the bytes in the windows stay unchanged.
- R9: Read data leaves the slave most significant bit first. The data-line enable changes only while the bus clock is low.
- R10: After a master not-acknowledge followed by STOP, the slave releases the data line.
- R11: A START that arrives part-way through a byte restarts address reception from its first bit.
- R12: host_rdata_o shows the stored byte at host_addr_i in the same cycle, and 00h for locations outside the windows. A write on the host port with host_we_i high is visible from the next cycle.
- R13: After reset, the data line is released and every location reads as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Wired level of the serial data line |
| sda_oe_o | output | 1 | High pulls the data line low |
| host_addr_i | input | 8 | Host port location |
| host_we_i | input | 1 | Host port write strobe |
| host_wdata_i | input | 8 | Host port write data |
| host_rdata_o | output | 8 | Host port read data, combinational |

## Verification
The data-line enable changes about three system clocks after the bus clock falls: two synchroniser stages plus one state register. The bench therefore keeps each bus clock phase at twelve system clocks and reads the data line six clocks into the high phase, after any change has settled and before the next one. A bus write lands in storage at the clock fall that ends its eighth bit, so the clock-by-clock comparison against the reference memory runs only while no transaction is in flight. The host read path has no register, so it is compared two nanoseconds after each falling clock edge, once the inputs for that cycle are stable.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  // one extra stage holds the previous level for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], line_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned W0_BASE = 8,
  parameter int unsigned W0_LEN  = 20,
  parameter int unsigned W1_BASE = 64,
  parameter int unsigned W1_LEN  = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o
);

  localparam int unsigned DEPTH = W0_LEN + W1_LEN;
  localparam int unsigned IW    = $clog2(DEPTH);

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic                     bus_hit, host_hit;
  logic [IW-1:0]            bus_idx, host_idx;

  function automatic logic [IW:0] slot_of(input logic [AW-1:0] a);
    int unsigned v;
    v = 32'(a);
    if (v >= W0_BASE && v < W0_BASE + W0_LEN) return {1'b1, IW'(v - W0_BASE)};
    if (v >= W1_BASE && v < W1_BASE + W1_LEN) return {1'b1, IW'(v - W1_BASE + W0_LEN)};
    return '0;
  endfunction

  always_comb begin
    {bus_hit, bus_idx}   = slot_of(bus_addr_i);
    {host_hit, host_idx} = slot_of(host_addr_i);
  end

  // bus write is applied last and so wins a same-slot collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      if (host_we_i && host_hit) mem_q[host_idx] <= host_wdata_i;
      if (bus_we_i && bus_hit)   mem_q[bus_idx]  <= bus_wdata_i;
    end
  end

  assign bus_rdata_o  = bus_hit  ? mem_q[bus_idx]  : '0;
  assign host_rdata_o = host_hit ? mem_q[host_idx] : '0;

  assert_unmapped_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !bus_hit && !host_we_i) |=> (mem_q == $past(mem_q)));

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_lvl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] ptr_o,
  output logic [7:0] wr_data_o
);

  slv_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       rw_q, oe_q, mack_q;
  logic       start, stop, rx_state, byte_end;

  assign start    = sda_fall_i & scl_lvl_i;
  assign stop     = sda_rise_i & scl_lvl_i;
  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_WORD) || (state_q == ST_WDATA);
  assign byte_end = rx_state && scl_fall_i && (cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (rx_state && scl_rise_i && cnt_q < 4'd8) begin
        rx_q  <= {rx_q[6:0], sda_lvl_i};
        cnt_q <= cnt_q + 4'd1;
      end
      case (state_q)
        ST_ADDR: if (byte_end) begin
          cnt_q <= '0;
          if (rx_q[7:1] == DEV_ADDR) begin
            rw_q    <= rx_q[0];
            oe_q    <= 1'b1;
            state_q <= ST_ADDR_ACK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WORD: if (byte_end) begin
          cnt_q   <= '0;
          ptr_q   <= rx_q;
          oe_q    <= 1'b1;
          state_q <= ST_WORD_ACK;
        end
        ST_WDATA: if (byte_end) begin
          cnt_q   <= '0;
          ptr_q   <= ptr_q + 8'd1;
          oe_q    <= 1'b1;
          state_q <= ST_WDATA_ACK;
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= rd_data_i;
            oe_q    <= ~rd_data_i[7];
            state_q <= ST_RDATA;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_WORD;
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: if (scl_fall_i) begin
          oe_q    <= 1'b0;
          state_q <= ST_WDATA;
        end
        ST_RDATA: if (scl_fall_i) begin
          if (cnt_q == 4'd7) begin
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            ptr_q   <= ptr_q + 8'd1;
            state_q <= ST_RACK;
          end else begin
            cnt_q <= cnt_q + 4'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
            oe_q  <= ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_q <= ~sda_lvl_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[7];
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_data_o = rx_q;
  assign wr_en_o   = (state_q == ST_WDATA) && byte_end && !start && !stop;

  assert_oe_when_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe_q) && !$past(start || stop)) |-> !scl_lvl_i);

  assert_idle_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);

  assert_start_rearms_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_ADDR && cnt_q == 4'd0));

  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK && $past(state_q) == ST_RDATA) |-> (ptr_q == 8'($past(ptr_q) + 8'd1)));

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned W0_BASE     = 8,
  parameter int unsigned W0_LEN      = 20,
  parameter int unsigned W1_BASE     = 64,
  parameter int unsigned W1_LEN      = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [7:0] host_addr_i,
  input  logic       host_we_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o
);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic       wr_en;
  logic [7:0] ptr, wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .rd_data_i(rd_data),
    .sda_oe_o, .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data)
  );

  i2c_reg_bank #(
    .AW(8), .DW(8),
    .W0_BASE(W0_BASE), .W0_LEN(W0_LEN), .W1_BASE(W1_BASE), .W1_LEN(W1_LEN)
  ) u_bank (
    .clk_i, .rst_ni,
    .bus_we_i(wr_en), .bus_addr_i(ptr), .bus_wdata_i(wr_data), .bus_rdata_o(rd_data),
    .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o
  );

endmodule

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;

  localparam logic [6:0] DEV = 7'h69;
  localparam int Q = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_w;
  logic       sda_oe_o;
  logic [7:0] host_addr_i = '0;
  logic       host_we_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  logic prev_oe = 1'b0;

  logic [7:0] mem_m [256];
  int ptr_m = 0;

  always #5 clk_i = ~clk_i;
  assign sda_w = sda_oe_o ? 1'b0 : m_sda;

  i2c_cfg_slave uut (
    .clk_i, .rst_ni, .scl_i(scl), .sda_i(sda_w), .sda_oe_o,
    .host_addr_i, .host_we_i, .host_wdata_i, .host_rdata_o
  );

  function automatic bit mapped(int a);
    return (a >= 8 && a <= 27) || (a >= 64 && a <= 87);
  endfunction

  function automatic logic [7:0] exp_at(int a);
    return mapped(a) ? mem_m[a] : 8'h00;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock while the bus is quiet
  always @(negedge clk_i) begin
    #2;
    if (rst_ni) begin
      if (mon_en) chk("R12", host_rdata_o, exp_at(host_addr_i));
      if (sda_oe_o !== prev_oe) chk("R9", scl, 0);
      prev_oe = sda_oe_o;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; wq(); scl = 1'b1; wq(); seen = sda_w; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string tag);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    chk(tag, s, exp_ack ? 0 : 1);
  endtask

  task automatic recv_byte(logic [7:0] exp, bit ack, string tag);
    logic s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    chk(tag, v, exp);
    clk_bit(!ack, s);
  endtask

  task automatic rd_seq(int n, string tag);
    logic [7:0] e;
    for (int k = 0; k < n; k++) begin
      e = exp_at(ptr_m);
      ptr_m = (ptr_m + 1) % 256;
      recv_byte(e, k < n - 1, tag);
    end
  endtask

  task automatic wr_txn(int word, logic [7:0] d[$], string tag);
    mon_en = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, 1, "R1");
    send_byte(8'(word), 1, tag);
    ptr_m = word;
    foreach (d[k]) begin
      send_byte(d[k], 1, tag);
      if (mapped(ptr_m)) mem_m[ptr_m] = d[k];
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
    mon_en = 1'b1;
  endtask

  task automatic rd_cur(int n, string tag);
    mon_en = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, 1, "R1");
    rd_seq(n, tag);
    bus_stop();
    chk("R10", sda_w, 1);
    mon_en = 1'b1;
  endtask

  task automatic rd_rand(int word, int n, string tag);
    mon_en = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, 1, "R1");
    send_byte(8'(word), 1, "R4");
    ptr_m = word;
    bus_start();
    send_byte({DEV, 1'b1}, 1, "R1");
    rd_seq(n, tag);
    bus_stop();
    chk("R10", sda_w, 1);
    mon_en = 1'b1;
  endtask

  task automatic host_wr(int a, logic [7:0] d);
    @(negedge clk_i);
    host_addr_i = 8'(a); host_wdata_i = d; host_we_i = 1'b1;
    @(negedge clk_i);
    host_we_i = 1'b0;
    if (mapped(a)) mem_m[a] = d;
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk_i);
      host_addr_i = 8'(a);
      #1;
      chk(tag, host_rdata_o, exp_at(a));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    foreach (mem_m[i]) mem_m[i] = 8'h00;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R13", sda_w, 1);
    sweep("R13");
    mon_en = 1'b1;

    // R1, R3: write three bytes from 08h
    wr_txn(8'h08, '{8'h11, 8'h22, 8'h33}, "R3");
    sweep("R3");

    // R12: host write, then R5 current-address read picks it up at 0Bh
    host_wr(8'h0B, 8'h5A);
    chk("R12", host_rdata_o, 8'h5A);
    rd_cur(1, "R5");

    // R4, R6: random read at 09h streaming three bytes, MSB first (R9)
    rd_rand(8'h09, 3, "R6");
    rd_cur(1, "R5");
    sweep("R4");

    // R2: foreign address NACKed, following byte ignored, pointer kept
    mon_en = 1'b0;
    bus_start();
    send_byte({7'h22, 1'b0}, 0, "R2");
    send_byte(8'h08, 0, "R2");
    bus_stop();
    chk("R2", sda_w, 1);
    rd_cur(1, "R2");

    // R8: unmapped write discarded, window edge at 57h
    wr_txn(8'h30, '{8'hAB}, "R8");
    rd_rand(8'h30, 1, "R8");
    wr_txn(8'h57, '{8'hD1, 8'hE2}, "R8");
    rd_rand(8'h57, 2, "R8");
    sweep("R8");

    // R7: pointer wraps FFh -> 00h, tenth byte lands at 08h
    wr_txn(8'hFF, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'hC7}, "R7");
    rd_rand(8'hFF, 10, "R7");

    // R11: START mid-byte restarts address reception
    mon_en = 1'b0;
    bus_start();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    bus_start();
    send_byte({DEV, 1'b1}, 1, "R11");
    rd_seq(1, "R11");
    bus_stop();
    chk("R10", sda_w, 1);
    mon_en = 1'b1;
    sweep("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule